// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Word

This block is the arithmetic core of a small 8-bit processor datapath. It holds an accumulator and a second operand register. On each cycle where its operation strobe is high it performs one of five arithmetic operations: add, add with carry, subtract with borrow, unsigned multiply or unsigned divide. It can also load both registers from operand inputs. Every arithmetic operation updates the carry, auxiliary carry and overflow flags of an 8-bit status word. The status word also holds a parity flag that always follows the accumulator, two flags reserved for software, and a two-bit bank selector.

Software can write the whole status word in one cycle, or write a single bit of it. The parity bit cannot be written. The bank selector relocates the eight working registers. A 3-bit register index is turned into a 5-bit internal memory address, so the four banks together cover addresses 0x00 to 0x1F. Fetch, decode, memory and interrupt handling are outside this block.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator, the second register and every status word bit are 0.
- R2: Opcode 0 (add) sets acc to (acc + b) mod 256. Carry (status bit 7) is the carry out of bit 7. Auxiliary carry (bit 6) is the carry from bit 3 into bit 4. Overflow (bit 2) is 1 exactly when the signed sum lies outside -128..127.
- R3: Opcode 1 adds the stored carry as well. Opcode 2 sets acc to acc - b - carry. For opcode 2, carry is the borrow out of bit 7, auxiliary carry is the borrow out of the low nibble, and overflow is set when the signed difference lies outside -128..127.
- R4: Opcode 3 puts the low byte of acc*b in acc and the high byte in b. It clears carry, sets overflow exactly when the product exceeds 255, and leaves auxiliary carry unchanged.
- R5: Opcode 4 with a nonzero b puts the quotient in acc and the remainder in b, and clears carry and overflow. With b equal to 0 it leaves acc and b unchanged, sets overflow and clears carry. Auxiliary carry is unchanged in both cases.
- R6: Opcode 5 loads acc from the first operand input and b from the second, with no flag change. Opcodes 6 and 7 change nothing.
- R7: Status bit 0 is always the XOR of the eight accumulator bits. Software writes to bit 0 have no effect.
- R8: A whole-word write loads status bits 7..1 from the write data. A single-bit write sets the selected bit (index 0..7) to the given value. When both happen in one cycle, the single-bit write wins for its bit.
- R9: When a software write and an arithmetic flag update fall in the same cycle, the arithmetic value wins for each flag that the operation affects. The other bits take the software value. The carry fed into the operation is the value held before that cycle.
- R10: The register address output equals 8*bank + index, where bank is status bits 4:3. It follows the index and the bank without a clock delay.
- R11: With no strobe and no status write, acc, b and the status word hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 multiply, 4 divide, 5 load) |
| ld_a | input | DATA_W | Accumulator load value |
| ld_b | input | DATA_W | Second register load value |
| psw_we | input | 1 | Whole status word write enable |
| psw_wdata | input | 8 | Status word write data |
| bit_we | input | 1 | Single status bit write enable |
| bit_sel | input | 3 | Status bit index for the single-bit write |
| bit_val | input | 1 | Value for the single-bit write |
| reg_idx | input | IDX_W | Working register index |
| acc_o | output | DATA_W | Accumulator |
| b_o | output | DATA_W | Second operand register |
| psw_o | output | 8 | Status word |
| reg_addr_o | output | IDX_W+2 | Mapped internal register address |

## Verification
The embedded properties assume that op_code is never X while op_valid is high. They also assume that the status write inputs are only meaningful while their enables are high, and that reset is released away from a clock edge. The bench drives every input at the falling edge from a seeded $urandom stream. It biases the second operand toward zero so that the zero-divisor path occurs often. It mixes in opcodes 6 and 7 and writes that collide with arithmetic, which keeps every combination inside the legal input space the properties rely on.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam logic [2:0] OP_ADD  = 3'd0;
   localparam logic [2:0] OP_ADDC = 3'd1;
   localparam logic [2:0] OP_SUBB = 3'd2;
   localparam logic [2:0] OP_MUL  = 3'd3;
   localparam logic [2:0] OP_DIV  = 3'd4;
   localparam logic [2:0] OP_LOAD = 3'd5;

   // status word bit positions
   localparam int SW_CY  = 7;
   localparam int SW_AC  = 6;
   localparam int SW_UF0 = 5;
   localparam int SW_BKH = 4;
   localparam int SW_BKL = 3;
   localparam int SW_OV  = 2;
   localparam int SW_UF1 = 1;
   localparam int SW_PAR = 0;

   typedef struct packed {
      logic cy_we;
      logic cy;
      logic ac_we;
      logic ac;
      logic ov_we;
      logic ov;
   } flag_upd_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] res,
   output logic         cy,
   output logic         ac,
   output logic         ov
);
   localparam int H = W / 2;

   logic [W-1:0] bx;
   logic         ci;
   logic         c_out;
   logic         c_msb;
   logic         c_half;

   // subtraction as a + ~b + ~borrow; carries invert into borrows
   assign bx = sub ? ~b : b;
   assign ci = sub ? ~cin : cin;

   assign {c_out, res} = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};

   // carry into a bit position recovered from the sum bit
   assign c_msb  = res[W-1] ^ a[W-1] ^ bx[W-1];
   assign c_half = res[H] ^ a[H] ^ bx[H];

   assign cy = sub ? ~c_out : c_out;
   assign ac = sub ? ~c_half : c_half;
   assign ov = c_out ^ c_msb;
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
   parameter int W = 8
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] prod,
   output logic [W-1:0]   quot,
   output logic [W-1:0]   rem,
   output logic           div_zero
);
   assign prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
   assign div_zero = (b == '0);

   // restoring divider, one stage per quotient bit, MSB first
   logic [W-1:0] rchain [W+1];
   assign rchain[0] = '0;

   for (genvar g = 0; g < W; g++) begin : g_stage
      logic [W:0] trial;
      logic [W:0] diff;
      assign trial = {rchain[g], a[W-1-g]};
      assign diff  = trial - {1'b0, b};
      assign quot[W-1-g] = ~diff[W];
      assign rchain[g+1] = diff[W] ? trial[W-1:0] : diff[W-1:0];
   end

   assign rem = rchain[W];
endmodule

// File: rtl/alu_psw.sv
module alu_psw
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sw_we,
   input  logic [7:1]   sw_data,
   input  logic         bit_we,
   input  logic [2:0]   bit_sel,
   input  logic         bit_val,
   input  flag_upd_t    upd,
   input  logic [W-1:0] acc,
   output logic [7:0]   psw
);
   logic [7:1] st_q;
   logic [7:1] st_n;

   always_comb begin
      st_n = st_q;
      if (sw_we) st_n = sw_data;
      if (bit_we && bit_sel != 3'd0) st_n[bit_sel] = bit_val;
      if (upd.cy_we) st_n[SW_CY] = upd.cy;
      if (upd.ac_we) st_n[SW_AC] = upd.ac;
      if (upd.ov_we) st_n[SW_OV] = upd.ov;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_n;
   end

   assign psw = {st_q, ^acc};

   AST_CY_ARITH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      upd.cy_we |=> psw[SW_CY] == $past(upd.cy)); // R9
   AST_OV_ARITH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      upd.ov_we |=> psw[SW_OV] == $past(upd.ov)); // R9
   AST_UF0_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !bit_we) |=> psw[SW_UF0] == $past(sw_data[SW_UF0])); // R8
endmodule

// File: rtl/alu_bank_map.sv
module alu_bank_map #(
   parameter int BANK_W = 2,
   parameter int IDX_W  = 3
) (
   input  logic [BANK_W-1:0]       bank,
   input  logic [IDX_W-1:0]        idx,
   output logic [BANK_W+IDX_W-1:0] addr
);
   // each bank spans 2**IDX_W consecutive addresses
   assign addr = {bank, idx};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [2:0]          op_code,
   input  logic [DATA_W-1:0]   ld_a,
   input  logic [DATA_W-1:0]   ld_b,
   input  logic                psw_we,
   input  logic [7:0]          psw_wdata,
   input  logic                bit_we,
   input  logic [2:0]          bit_sel,
   input  logic                bit_val,
   input  logic [IDX_W-1:0]    reg_idx,
   output logic [DATA_W-1:0]   acc_o,
   output logic [DATA_W-1:0]   b_o,
   output logic [7:0]          psw_o,
   output logic [IDX_W+1:0]    reg_addr_o
);
   localparam int BANK_W = SW_BKH - SW_BKL + 1;

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("acc_alu: DATA_W must be even and at least 4");
   end
   if (IDX_W < 1 || IDX_W > 6) begin : g_bad_idx
      $error("acc_alu: IDX_W must lie in 1..6");
   end

   logic [DATA_W-1:0]   acc_q, acc_n;
   logic [DATA_W-1:0]   b_q, b_n;
   flag_upd_t           upd;
   logic                cy_now;
   logic                as_cin, as_sub;
   logic [DATA_W-1:0]   as_res;
   logic                as_cy, as_ac, as_ov;
   logic [2*DATA_W-1:0] prod;
   logic [DATA_W-1:0]   quot, rem;
   logic                div_zero;
   logic                unused_par_wr;

   assign unused_par_wr = psw_wdata[SW_PAR];
   assign cy_now        = psw_o[SW_CY];
   assign as_sub        = (op_code == OP_SUBB);
   assign as_cin        = (op_code == OP_ADD) ? 1'b0 : cy_now;

   alu_addsub #(.W(DATA_W)) u_addsub (
      .a(acc_q), .b(b_q), .cin(as_cin), .sub(as_sub),
      .res(as_res), .cy(as_cy), .ac(as_ac), .ov(as_ov)
   );

   alu_muldiv #(.W(DATA_W)) u_muldiv (
      .a(acc_q), .b(b_q), .prod(prod), .quot(quot), .rem(rem),
      .div_zero(div_zero)
   );

   always_comb begin
      acc_n = acc_q;
      b_n   = b_q;
      upd   = '0;
      if (op_valid) begin
         case (op_code)
            OP_ADD, OP_ADDC, OP_SUBB: begin
               acc_n     = as_res;
               upd.cy_we = 1'b1;  upd.cy = as_cy;
               upd.ac_we = 1'b1;  upd.ac = as_ac;
               upd.ov_we = 1'b1;  upd.ov = as_ov;
            end
            OP_MUL: begin
               acc_n     = prod[DATA_W-1:0];
               b_n       = prod[2*DATA_W-1:DATA_W];
               upd.cy_we = 1'b1;  upd.cy = 1'b0;
               upd.ov_we = 1'b1;  upd.ov = |prod[2*DATA_W-1:DATA_W];
            end
            OP_DIV: begin
               upd.cy_we = 1'b1;  upd.cy = 1'b0;
               upd.ov_we = 1'b1;  upd.ov = div_zero;
               if (!div_zero) begin
                  acc_n = quot;
                  b_n   = rem;
               end
            end
            OP_LOAD: begin
               acc_n = ld_a;
               b_n   = ld_b;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         b_q   <= '0;
      end else begin
         acc_q <= acc_n;
         b_q   <= b_n;
      end
   end

   alu_psw #(.W(DATA_W)) u_psw (
      .clk(clk), .rst_n(rst_n),
      .sw_we(psw_we), .sw_data(psw_wdata[7:1]),
      .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val),
      .upd(upd), .acc(acc_q), .psw(psw_o)
   );

   alu_bank_map #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_map (
      .bank(psw_o[SW_BKH:SW_BKL]), .idx(reg_idx), .addr(reg_addr_o)
   );

   assign acc_o = acc_q;
   assign b_o   = b_q;

   AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_ADD) |=>
      {psw_o[SW_CY], acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(b_o)})); // R2
   AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_MUL) |=>
      !psw_o[SW_CY] && (psw_o[SW_OV] == (b_o != '0))); // R4
   AST_DIV_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_DIV && b_o == '0) |=>
      psw_o[SW_OV] && $stable(acc_o) && $stable(b_o)); // R5
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !psw_we && !bit_we) |=>
      $stable(acc_o) && $stable(b_o) && $stable(psw_o)); // R11
   AST_LOAD_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_LOAD && !psw_we && !bit_we) |=>
      psw_o[7:1] == $past(psw_o[7:1])); // R6
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [2:0] op_code = '0;
   logic [7:0] ld_a = '0, ld_b = '0;
   logic       psw_we = 1'b0;
   logic [7:0] psw_wdata = '0;
   logic       bit_we = 1'b0;
   logic [2:0] bit_sel = '0;
   logic       bit_val = 1'b0;
   logic [2:0] reg_idx = '0;
   logic [7:0] acc_o, b_o, psw_o;
   logic [4:0] reg_addr_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] m_acc = '0, m_b = '0;
   logic [7:1] m_st = '0;

   always #2.5 clk = ~clk;

   acc_alu dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .ld_a(ld_a), .ld_b(ld_b), .psw_we(psw_we), .psw_wdata(psw_wdata),
      .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val),
      .reg_idx(reg_idx), .acc_o(acc_o), .b_o(b_o), .psw_o(psw_o),
      .reg_addr_o(reg_addr_o)
   );

   function automatic int sx(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   // reference next state from the requirements
   task automatic model(input logic v, input logic [2:0] op,
                        input logic pwe, input logic [7:0] pwd,
                        input logic bwe, input logic [2:0] bs, input logic bv);
      logic [7:1] st;
      int a, b, cin, r, sr;
      st  = m_st;
      a   = int'(m_acc);
      b   = int'(m_b);
      cin = int'(m_st[7]);
      if (pwe) st = pwd[7:1];
      if (bwe && bs != 3'd0) st[bs] = bv;
      if (v) begin
         case (op)
            3'd0, 3'd1: begin
               if (op == 3'd0) cin = 0;
               r  = a + b + cin;
               sr = sx(a) + sx(b) + cin;
               st[7] = (r > 255);
               st[6] = ((a % 16) + (b % 16) + cin) > 15;
               st[2] = (sr > 127) || (sr < -128);
               m_acc = 8'(r);
            end
            3'd2: begin
               r  = a - b - cin;
               sr = sx(a) - sx(b) - cin;
               st[7] = (r < 0);
               st[6] = ((a % 16) - (b % 16) - cin) < 0;
               st[2] = (sr > 127) || (sr < -128);
               m_acc = 8'(r + 256);
            end
            3'd3: begin
               r = a * b;
               st[7] = 1'b0;
               st[2] = (r > 255);
               m_acc = 8'(r % 256);
               m_b   = 8'(r / 256);
            end
            3'd4: begin
               st[7] = 1'b0;
               st[2] = (b == 0);
               if (b != 0) begin
                  m_acc = 8'(a / b);
                  m_b   = 8'(a % b);
               end
            end
            3'd5: begin
               m_acc = ld_a;
               m_b   = ld_b;
            end
            default: ;
         endcase
      end
      m_st = st;
   endtask

   task automatic compare(input string req);
      logic [7:0] ep;
      int ea;
      ep = {m_st, ^m_acc};
      ea = 8 * int'(m_st[4:3]) + int'(reg_idx);
      n_vec++;
      if (acc_o !== m_acc || b_o !== m_b || psw_o !== ep || int'(reg_addr_o) != ea) begin
         n_bad++;
         $display("FAIL %s: acc=%02h b=%02h psw=%02h addr=%02h expected acc=%02h b=%02h psw=%02h addr=%02h",
                  req, acc_o, b_o, psw_o, reg_addr_o, m_acc, m_b, ep, ea);
      end
   endtask

   task automatic apply(input logic v, input logic [2:0] op,
                        input logic [7:0] a, input logic [7:0] b,
                        input logic pwe, input logic [7:0] pwd,
                        input logic bwe, input logic [2:0] bs, input logic bv,
                        input logic [2:0] idx, input string req);
      op_valid = v;  op_code = op;  ld_a = a;  ld_b = b;
      psw_we = pwe;  psw_wdata = pwd;
      bit_we = bwe;  bit_sel = bs;  bit_val = bv;
      reg_idx = idx;
      model(v, op, pwe, pwd, bwe, bs, bv);
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   function automatic string req_for(input logic v, input logic [2:0] op,
                                     input logic anyw);
      if (v && anyw && op <= 3'd4) return "R9";
      if (anyw) return "R8";
      if (!v) return "R11";
      case (op)
         3'd0: return "R2";
         3'd1, 3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         default: return "R6";
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");                          // reset state
      rst_n = 1'b1;
      @(negedge clk);

      // directed corner cases
      apply(1, 3'd5, 8'h7F, 8'h01, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd0, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd1, "R2"); // 7F+01 signed overflow, half carry
      apply(1, 3'd5, 8'hFF, 8'h01, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd0, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R2"); // carry out, result 0
      apply(1, 3'd5, 8'h10, 8'h0F, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd1, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R3"); // carry-in consumed
      apply(1, 3'd5, 8'h80, 8'h01, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd2, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R3"); // 80-01 signed overflow
      apply(1, 3'd2, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R3");
      apply(1, 3'd5, 8'h00, 8'h01, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd2, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R3"); // borrow
      apply(1, 3'd5, 8'hFF, 8'hFF, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd3, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R4"); // FE01
      apply(1, 3'd5, 8'h0F, 8'h11, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd3, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R4"); // FF, no overflow
      apply(1, 3'd5, 8'h25, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd4, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R5"); // zero divisor
      apply(1, 3'd5, 8'h64, 8'h07, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd4, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R5"); // 100/7
      apply(1, 3'd5, 8'hFF, 8'h01, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R5");
      apply(1, 3'd4, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R5"); // divide by one
      apply(1, 3'd6, 8'hAA, 8'h55, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd7, 8'hAA, 8'h55, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R6");
      apply(1, 3'd5, 8'h07, 8'h00, 0, 8'h00, 0, 3'd0, 0, 3'd0, "R7");
      apply(0, 3'd0, 8'h00, 8'h00, 1, 8'h00, 1, 3'd0, 1, 3'd0, "R7"); // bit 0 write ignored
      apply(0, 3'd0, 8'h00, 8'h00, 1, 8'hFF, 0, 3'd0, 0, 3'd5, "R7");
      apply(0, 3'd0, 8'h00, 8'h00, 1, 8'h00, 1, 3'd5, 1, 3'd5, "R8"); // bit wins over word
      apply(1, 3'd0, 8'h00, 8'h00, 1, 8'hFF, 1, 3'd7, 0, 3'd2, "R9"); // flags from add
      apply(0, 3'd0, 8'h00, 8'h00, 1, 8'h18, 0, 3'd0, 0, 3'd7, "R10"); // bank 3 idx 7
      reg_idx = 3'd2;
      #1;
      compare("R10");                          // address follows index without a clock
      apply(0, 3'd0, 8'h00, 8'h00, 1, 8'h08, 0, 3'd0, 0, 3'd4, "R10");
      apply(0, 3'd3, 8'hFF, 8'hFF, 0, 8'h00, 0, 3'd0, 0, 3'd4, "R11");

      // seeded random mix
      void'($urandom(32'h5EED_0A1C));
      for (int i = 0; i < 4000; i++) begin
         logic v, pwe, bwe;
         logic [2:0] op;
         logic [7:0] a, b;
         v   = ($urandom % 10) < 7;
         op  = 3'($urandom % 8);
         pwe = ($urandom % 10) == 0;
         bwe = ($urandom % 10) == 0;
         a   = 8'($urandom);
         b   = (($urandom % 8) == 0) ? 8'h00 : 8'($urandom);
         apply(v, op, a, b, pwe, 8'($urandom), bwe, 3'($urandom), 1'($urandom),
               3'($urandom), req_for(v, op, pwe | bwe));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule